// File: doc/BRIEF.md
# SDRAM Power-Mode Sequencer

This block controls power modes for a single-rank SDRAM controller. Two configuration inputs set the enables for the pins. One is a master enable for the SDRAM interface. The other switches on a second clock pin for boards with a heavy clock load. The block accepts access requests from an internal bus. While the interface is disabled, it answers each request with a one-cycle bus error and sends nothing to the pins.

While the interface is enabled, requests are counted and served one at a time through a start/done handshake with an abstract data path. The block also takes refresh ticks and a software write that asks for self-refresh. Before entering self-refresh it serves every queued access, including accesses that arrive while it waits. It closes an open row with a precharge, waits the row-precharge time, and then issues the self-refresh entry command. A status output shows when the memory is in self-refresh, so software knows the clocks may be gated. Any new request wakes the memory. The block issues the exit command, waits the exit-to-command time, and then serves the request. Leaving self-refresh also clears the software request.

Top module: `sdram_pwr_seq`

## Requirements
- R1: With `cfg_ctl_en`=1 and `cfg_clk1_en`=0, `clk0_oe` and `ctl_oe` are 1 and `clk1_oe` is 0.
- R2: With both configuration inputs 1, all three pin enables are 1. With `cfg_ctl_en`=0, all three are 0.
- R3: A `bus_req` sampled while `cfg_ctl_en`=0 drives `bus_err` high for exactly the next cycle. It produces no command and no `acc_start`.
- R4: A `ref_tick` seen while enabled leads to a refresh command (code 2), preceded by a precharge if a row is open. A tick seen while disabled is dropped and never yields a refresh.
- R5: A self-refresh write (`sr_wr`) with `sr_wdata`=0 starts nothing: no command is issued and `sr_active` stays 0.
- R6: Self-refresh entry issues precharge (code 1) and then entry (code 3) when a row is open. When no row is open, it issues entry alone. A row is opened by each access and closed by precharge.
- R7: Self-refresh entry is held back until every pending access is served, including accesses accepted after the request.
- R8: The command that follows a precharge comes exactly TRP_CYC+1 cycles after it when nothing is pending. `sr_active` rises in the cycle the entry command appears.
- R9: A request accepted during self-refresh causes the exit command (code 4) and clears `sr_active` in the same cycle. `acc_start` follows exactly TXSR_CYC+1 cycles after the exit command. The software request is cleared, so entry does not repeat.
- R10: `cmd` is 0 when idle, and each command lasts one cycle. `acc_start` is a one-cycle pulse, and only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ctl_en | input | 1 | Master enable of the SDRAM interface |
| cfg_clk1_en | input | 1 | Enable of the second clock pin |
| sr_wr | input | 1 | Write strobe of the self-refresh request |
| sr_wdata | input | 1 | Value written; 1 requests self-refresh |
| ref_tick | input | 1 | Refresh interval elapsed |
| bus_req | input | 1 | One-cycle access request |
| bus_err | output | 1 | Bus error for a request made while disabled |
| acc_start | output | 1 | Start one access on the data path |
| acc_done | input | 1 | Data path finished the access |
| cmd | output | 3 | Command to the pin driver: 0 none, 1 precharge, 2 refresh, 3 SR entry, 4 SR exit |
| clk0_oe | output | 1 | Enable of clock pin 0 |
| clk1_oe | output | 1 | Enable of clock pin 1 |
| ctl_oe | output | 1 | Enable of the control pins |
| sr_active | output | 1 | Memory is in self-refresh |

## Verification
An open-row flag that is stuck shows up at the next entry or refresh. A spurious precharge code appears, or an expected one is missing, within one cycle of the decision. A pending count that drops too early lets the entry command jump ahead of a queued access, so the order of events on `cmd` and `acc_start` changes at once. Wait counters that are off by one show as a wrong spacing, in cycles, between a precharge or exit and the command after it. The bench measures that spacing exactly.

// File: rtl/sdram_pwr_seq.sv
module sdram_pwr_seq #(
  parameter int TRP_CYC  = 3,
  parameter int TXSR_CYC = 8,
  parameter int PEND_W   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_ctl_en,
  input  logic       cfg_clk1_en,
  input  logic       sr_wr,
  input  logic       sr_wdata,
  input  logic       ref_tick,
  input  logic       bus_req,
  output logic       bus_err,
  output logic       acc_start,
  input  logic       acc_done,
  output logic [2:0] cmd,
  output logic       clk0_oe,
  output logic       clk1_oe,
  output logic       ctl_oe,
  output logic       sr_active
);

  localparam int WMAX = (TRP_CYC > TXSR_CYC) ? TRP_CYC : TXSR_CYC;
  localparam int CW   = $clog2(WMAX + 1);
  localparam logic [PEND_W-1:0] PMAX = '1;
  localparam logic [2:0] C_NOP = 3'd0, C_PRE = 3'd1, C_REF = 3'd2, C_SRE = 3'd3, C_SRX = 3'd4;

  typedef enum logic [2:0] {ST_RUN, ST_ACC, ST_TRP, ST_SR, ST_TXSR} st_t;

  st_t             st;
  logic [CW-1:0]   wcnt;
  logic [PEND_W-1:0] pend, pend_nx;
  logic            row_open, sr_pend, ref_due;
  logic            new_req, done_now;

  assign clk0_oe = cfg_ctl_en;
  assign ctl_oe  = cfg_ctl_en;
  assign clk1_oe = cfg_ctl_en & cfg_clk1_en;

  assign new_req  = bus_req & cfg_ctl_en;
  assign done_now = (st == ST_ACC) & acc_done;

  always_comb begin
    pend_nx = pend;
    if (new_req && !done_now)      pend_nx = pend + 1'b1;
    else if (!new_req && done_now) pend_nx = pend - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_RUN;
      wcnt      <= '0;
      pend      <= '0;
      row_open  <= 1'b0;
      sr_pend   <= 1'b0;
      ref_due   <= 1'b0;
      cmd       <= C_NOP;
      acc_start <= 1'b0;
      bus_err   <= 1'b0;
      sr_active <= 1'b0;
    end else begin
      cmd       <= C_NOP;
      acc_start <= 1'b0;
      bus_err   <= bus_req & ~cfg_ctl_en;
      pend      <= pend_nx;
      if (sr_wr && sr_wdata) sr_pend <= 1'b1;
      if (!cfg_ctl_en) ref_due <= 1'b0;
      else if (ref_tick && st != ST_SR) ref_due <= 1'b1;

      case (st)
        ST_RUN: begin
          if (pend != '0) begin
            acc_start <= 1'b1;
            row_open  <= 1'b1;
            st        <= ST_ACC;
          end else if (sr_pend && !new_req) begin
            if (row_open) begin
              cmd      <= C_PRE;
              row_open <= 1'b0;
              wcnt     <= CW'(TRP_CYC - 1);
              st       <= ST_TRP;
            end else begin
              cmd       <= C_SRE;
              sr_active <= 1'b1;
              ref_due   <= 1'b0;
              st        <= ST_SR;
            end
          end else if (ref_due && cfg_ctl_en) begin
            if (row_open) begin
              cmd      <= C_PRE;
              row_open <= 1'b0;
              wcnt     <= CW'(TRP_CYC - 1);
              st       <= ST_TRP;
            end else begin
              cmd     <= C_REF;
              ref_due <= 1'b0;
            end
          end
        end
        ST_ACC: if (acc_done) st <= ST_RUN;
        ST_TRP, ST_TXSR: begin
          if (wcnt == '0) st <= ST_RUN;
          else wcnt <= wcnt - 1'b1;
        end
        ST_SR: begin
          if (pend != '0) begin
            cmd       <= C_SRX;
            sr_active <= 1'b0;
            sr_pend   <= 1'b0;
            wcnt      <= CW'(TXSR_CYC - 1);
            st        <= ST_TXSR;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assert_err_no_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !acc_start);
  assert_ref_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF) |-> $past(cfg_ctl_en));
  assert_closed_before_sre_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_SRE) |-> !row_open);
  assert_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_SRE) |-> (pend == '0));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    new_req |-> (pend != PMAX));
  assert_status_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_SRE) |-> sr_active);
  assert_exit_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_SRX) |-> (!sr_active && !sr_pend));
  assert_no_access_in_sr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> !acc_start);
  assert_single_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> !acc_start);

endmodule

// File: tb/sdram_pwr_seq_test.sv
module sdram_pwr_seq_test;
  localparam int TRP  = 3;
  localparam int TXSR = 8;
  localparam int EV_ACC = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_ctl_en = 0, cfg_clk1_en = 0, sr_wr = 0, sr_wdata = 0, ref_tick = 0, bus_req = 0;
  logic acc_done = 0;
  logic bus_err, acc_start, clk0_oe, clk1_oe, ctl_oe, sr_active;
  logic [2:0] cmd;

  int checks = 0, errors = 0;
  int exp_kind[$], exp_gap[$];
  string exp_tag[$];
  int cyc = 0, last_cyc = 0, done_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sdram_pwr_seq #(.TRP_CYC(TRP), .TXSR_CYC(TXSR), .PEND_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_ctl_en(cfg_ctl_en), .cfg_clk1_en(cfg_clk1_en),
    .sr_wr(sr_wr), .sr_wdata(sr_wdata), .ref_tick(ref_tick), .bus_req(bus_req),
    .bus_err(bus_err), .acc_start(acc_start), .acc_done(acc_done), .cmd(cmd),
    .clk0_oe(clk0_oe), .clk1_oe(clk1_oe), .ctl_oe(ctl_oe), .sr_active(sr_active));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_ev(int kind, int gap, string tag);
    exp_kind.push_back(kind); exp_gap.push_back(gap); exp_tag.push_back(tag);
  endtask

  // data path model: done two cycles after start
  always @(negedge clk) begin
    acc_done <= 1'b0;
    if (acc_start) done_cnt <= 2;
    else if (done_cnt > 0) begin
      done_cnt <= done_cnt - 1;
      if (done_cnt == 1) acc_done <= 1'b1;
    end
  end

  // monitor: compare event stream against the expected queue
  always @(negedge clk) begin
    if (rst_n) begin
      int ev;
      cyc++;
      ev = (cmd != 3'd0) ? int'(cmd) : (acc_start ? EV_ACC : 0);
      if (ev != 0) begin
        if (exp_kind.size() == 0) begin
          check("R10 unexpected event", ev, 0);
        end else begin
          int k, g;
          string t;
          k = exp_kind.pop_front(); g = exp_gap.pop_front(); t = exp_tag.pop_front();
          check(t, ev, k);
          if (g >= 0) check({t, " spacing"}, cyc - last_cyc, g);
        end
        last_cyc = cyc;
      end
    end
  end

  task automatic req();
    @(negedge clk) bus_req = 1;
    @(negedge clk) bus_req = 0;
  endtask

  task automatic sr_write(logic v);
    @(negedge clk) begin sr_wr = 1; sr_wdata = v; end
    @(negedge clk) begin sr_wr = 0; sr_wdata = 0; end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R10 reset cmd", int'(cmd), 0);
    check("R8 reset sr_active", int'(sr_active), 0);
    check("R3 reset bus_err", int'(bus_err), 0);
    check("R2 disabled pins", int'({clk0_oe, clk1_oe, ctl_oe}), 0);
    @(negedge clk) rst_n = 1;
    idle(2);

    // R3: request while disabled
    @(negedge clk) bus_req = 1;
    @(negedge clk) bus_req = 0;
    check("R3 bus_err pulse", int'(bus_err), 1);
    @(negedge clk);
    check("R3 bus_err one cycle", int'(bus_err), 0);
    // R4: refresh tick while disabled is dropped
    @(negedge clk) ref_tick = 1;
    @(negedge clk) ref_tick = 0;
    idle(3);

    @(negedge clk) begin cfg_ctl_en = 1; cfg_clk1_en = 1; end
    @(negedge clk);
    check("R2 both enabled", int'({clk0_oe, clk1_oe, ctl_oe}), 7);
    cfg_clk1_en = 0;
    @(negedge clk);
    check("R1 clk1 held low", int'({clk0_oe, clk1_oe, ctl_oe}), 5);
    idle(10);
    check("R4 no refresh from disabled tick", exp_kind.size(), 0);

    // R5: write of 0
    sr_write(0);
    idle(15);
    check("R5 sr_active after write 0", int'(sr_active), 0);

    // R6/R8: access opens row, then entry via precharge
    expect_ev(EV_ACC, -1, "R10 access");
    req();
    idle(8);
    expect_ev(1, -1, "R6 precharge before entry");
    expect_ev(3, TRP + 1, "R8 entry after precharge");
    sr_write(1);
    idle(15);
    check("R8 sr_active in self-refresh", int'(sr_active), 1);

    // R9: wake by request
    expect_ev(4, -1, "R9 exit");
    expect_ev(EV_ACC, TXSR + 1, "R9 access after exit");
    req();
    idle(25);
    check("R9 sr_active after exit", int'(sr_active), 0);
    check("R9 no re-entry", exp_kind.size(), 0);

    // R7: drain including late arrivals
    expect_ev(EV_ACC, -1, "R7 access 1");
    expect_ev(EV_ACC, -1, "R7 access 2");
    expect_ev(EV_ACC, -1, "R7 access 3");
    expect_ev(1, -1, "R7 precharge after drain");
    expect_ev(3, TRP + 1, "R7 entry after drain");
    req(); req(); sr_write(1); req();
    idle(40);
    check("R7 in self-refresh", int'(sr_active), 1);
    expect_ev(4, -1, "R9 exit 2");
    expect_ev(EV_ACC, TXSR + 1, "R9 access after exit 2");
    req();
    idle(25);

    // R4/R6: refresh closes the row, then entry without precharge
    expect_ev(1, -1, "R4 precharge before refresh");
    expect_ev(2, TRP + 1, "R4 refresh");
    @(negedge clk) ref_tick = 1;
    @(negedge clk) ref_tick = 0;
    idle(15);
    expect_ev(3, -1, "R6 entry with closed row");
    sr_write(1);
    idle(10);
    check("R6 sr_active closed row", int'(sr_active), 1);
    expect_ev(4, -1, "R9 exit 3");
    expect_ev(EV_ACC, TXSR + 1, "R9 access after exit 3");
    req();
    idle(25);

    check("R10 all events seen", exp_kind.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule